// File: doc/BRIEF.md
# Page Column Pointer Controller

This block keeps the byte pointer and page address used while a paged flash array is read out serially or loaded with write data. A decoded read-mode command picks where in the page the pointer starts: the low half of the main area, the high half of the main area, or the 16-byte spare area. Three address bytes then give the start column and the page address. Each byte strobe moves the pointer on by one. The byte strobe is the read-enable falling edge in read mode, or the data-load strobe while write data is entered.

When the pointer passes the last column of the page, the block moves to the next page and raises a one-cycle load request so the array can fetch it. The pointer then restarts at column 0, or at column 512 in spare mode. If the next page would fall in a new block, the block does not advance. It raises a stop flag instead, and that flag holds until a new command and a full address are given. A size input selects 528-byte pages or 512-byte pages. In the 512-byte case the spare area does not exist.

Top module: `page_pointer_ctrl`

## Requirements
- R1: After reset, col is 0, page is 0, load_req and blk_stop are 0, and the pointer is in the main area.
- R2: A command is applied when cmd_vld is 1. The code on cmd_sel means: 2'b00 sets the main area with a low start and moves col to 0. 2'b01 sets the main area with a high start and moves col to 256. 2'b10 sets spare mode and moves col to 512. 2'b11 keeps the area and start and leaves col as it is. Every applied command restarts address capture at the first byte.
- R3: The first address byte sets col to {high-start bit, byte} in the main area. In spare mode it sets col to 512 + byte[3:0], and byte bits 7..4 are ignored.
- R4: Spare mode persists across later commands of code 2'b11 and across page advances. Only code 2'b00 or 2'b01 returns the pointer to the main area.
- R5: small_page=0 gives a last column of 527. small_page=1 gives a last column of 511, and there a 2'b10 command has no effect at all.
- R6: A step pulse moves col up by one while col is below the last column. This also happens before any address has been given.
- R7: A step at the last column moves page to page+1 and col to 0, or to 512 in spare mode. It also drives load_req to 1 for exactly one cycle, provided page[4:0] is not 31.
- R8: The second address byte loads page[7:0]. The third byte loads page[14:8] from bits 6..0 and ignores bit 7. The third byte drives load_req to 1 for one cycle and clears blk_stop. Any further bytes are ignored until the next command.
- R9: A step at the last column when page[4:0] is 31 sets blk_stop and leaves page and col unchanged, with no load_req. While blk_stop is 1, steps have no effect.
- R10: In one cycle a command takes precedence over an address byte, and an address byte takes precedence over a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| small_page | input | 1 | 1 selects 512-byte pages with no spare area |
| cmd_vld | input | 1 | Command strobe |
| cmd_sel | input | 2 | Decoded command code |
| addr_vld | input | 1 | Address byte strobe |
| addr_byte | input | 8 | Address byte value |
| step | input | 1 | One pulse per byte read out or loaded |
| col | output | 10 | Current column |
| page | output | 15 | Page address; bits 14..5 are the block number |
| load_req | output | 1 | One-cycle request to load the selected page |
| blk_stop | output | 1 | Advance stopped at a block boundary |

## Verification
The assertions check, on every cycle, that the column stays inside the page and inside the spare window. They also check the single increment on a step, the page advance with its load request at a page end, and the hold at a block end. Only the bench scenarios show how an address sequence turns into a start column and page. They also show that spare mode survives a new address, that a fourth address byte is ignored, and that the spare command is rejected with 512-byte pages.

// File: rtl/page_ptr_pkg.sv
package page_ptr_pkg;
   typedef enum logic [1:0] {
      CMD_LOW   = 2'b00,
      CMD_HIGH  = 2'b01,
      CMD_SPARE = 2'b10,
      CMD_KEEP  = 2'b11
   } cmd_code_e;
endpackage

// File: rtl/page_ptr_region.sv
module page_ptr_region
   import page_ptr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       small_page,
   input  logic       cmd_vld,
   input  logic [1:0] cmd_sel,
   input  logic       addr_vld,
   output logic       cmd_take,
   output logic       spare_q,
   output logic       hi_q,
   output logic [2:0] take_byte
);
   cmd_code_e  code;
   logic [1:0] bidx_q;

   assign code = cmd_code_e'(cmd_sel);

   always_comb begin
      cmd_take = cmd_vld;
      if (code == CMD_SPARE && small_page)
         cmd_take = 1'b0;
   end

   always_comb begin
      take_byte = '0;
      if (addr_vld && !cmd_vld) begin
         case (bidx_q)
            2'd0:    take_byte[0] = 1'b1;
            2'd1:    take_byte[1] = 1'b1;
            2'd2:    take_byte[2] = 1'b1;
            default: take_byte = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         spare_q <= 1'b0;
         hi_q    <= 1'b0;
         bidx_q  <= 2'd0;
      end else if (cmd_take) begin
         bidx_q <= 2'd0;
         case (code)
            CMD_LOW:   begin spare_q <= 1'b0; hi_q <= 1'b0; end
            CMD_HIGH:  begin spare_q <= 1'b0; hi_q <= 1'b1; end
            CMD_SPARE: begin spare_q <= 1'b1; hi_q <= 1'b0; end
            default:   ;
         endcase
      end else if (addr_vld && !cmd_vld && bidx_q != 2'd3) begin
         bidx_q <= bidx_q + 2'd1;
      end
   end
endmodule

// File: rtl/page_ptr_column.sv
module page_ptr_column
   import page_ptr_pkg::*;
#(
   parameter int MAIN_BYTES  = 512,
   parameter int SPARE_BYTES = 16,
   localparam int COL_W  = $clog2(MAIN_BYTES + SPARE_BYTES),
   localparam int OFF_W  = $clog2(SPARE_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             small_page,
   input  logic             cmd_take,
   input  logic [1:0]       cmd_sel,
   input  logic             load_first,
   input  logic [7:0]       addr_byte,
   input  logic             spare,
   input  logic             hi,
   input  logic             adv,
   input  logic             blk_end,
   output logic             at_last,
   output logic [COL_W-1:0] col_q
);
   localparam logic [COL_W-1:0] HALF  = COL_W'(MAIN_BYTES / 2);
   localparam logic [COL_W-1:0] SBASE = COL_W'(MAIN_BYTES);
   localparam logic [COL_W-1:0] LAST_L = COL_W'(MAIN_BYTES + SPARE_BYTES - 1);
   localparam logic [COL_W-1:0] LAST_S = COL_W'(MAIN_BYTES - 1);

   logic [COL_W-1:0] last;
   logic [COL_W-1:0] first_col;

   generate
      if (SPARE_BYTES > 0) begin : g_opt
         assign last = small_page ? LAST_S : LAST_L;
      end else begin : g_fixed
         logic unused_sz;
         assign unused_sz = small_page;
         assign last = LAST_S;
      end
   endgenerate

   assign at_last = (col_q == last);

   always_comb begin
      if (spare)
         first_col = SBASE + COL_W'(addr_byte[OFF_W-1:0]);
      else
         first_col = {{(COL_W-9){1'b0}}, hi, addr_byte};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q <= '0;
      end else if (cmd_take) begin
         case (cmd_code_e'(cmd_sel))
            CMD_LOW:   col_q <= '0;
            CMD_HIGH:  col_q <= HALF;
            CMD_SPARE: col_q <= SBASE;
            default:   ;
         endcase
      end else if (load_first) begin
         col_q <= first_col;
      end else if (adv) begin
         if (!at_last)
            col_q <= col_q + 1'b1;
         else if (!blk_end)
            col_q <= spare ? SBASE : '0;
      end
   end
endmodule

// File: rtl/page_ptr_page.sv
module page_ptr_page #(
   parameter int PG_IN_BLK_W = 5,
   parameter int BLK_W       = 10,
   localparam int PA_W = PG_IN_BLK_W + BLK_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_lo,
   input  logic            load_hi,
   input  logic [7:0]      addr_byte,
   input  logic            inc,
   output logic            blk_end,
   output logic [PA_W-1:0] page_q
);
   assign blk_end = &page_q[PG_IN_BLK_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)
         page_q <= '0;
      else if (load_lo)
         page_q[7:0] <= addr_byte;
      else if (load_hi)
         page_q[PA_W-1:8] <= addr_byte[PA_W-9:0];
      else if (inc)
         page_q <= page_q + 1'b1;
   end
endmodule

// File: rtl/page_pointer_ctrl.sv
module page_pointer_ctrl #(
   parameter int MAIN_BYTES  = 512,
   parameter int SPARE_BYTES = 16,
   parameter int PG_IN_BLK_W = 5,
   parameter int BLK_W       = 10,
   localparam int COL_W = $clog2(MAIN_BYTES + SPARE_BYTES),
   localparam int PA_W  = PG_IN_BLK_W + BLK_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             small_page,
   input  logic             cmd_vld,
   input  logic [1:0]       cmd_sel,
   input  logic             addr_vld,
   input  logic [7:0]       addr_byte,
   input  logic             step,
   output logic [COL_W-1:0] col,
   output logic [PA_W-1:0]  page,
   output logic             load_req,
   output logic             blk_stop
);
   generate
      if (MAIN_BYTES != 512) begin : g_bad_main
         $error("MAIN_BYTES must be 512: one implied bit above an 8-bit byte");
      end
      if (PA_W != 15) begin : g_bad_pa
         $error("page address must be 15 bits: 8 plus 7 from two bytes");
      end
      if (SPARE_BYTES != 0 && SPARE_BYTES != 16) begin : g_bad_spare
         $error("SPARE_BYTES must be 0 or 16");
      end
   endgenerate

   logic       cmd_take;
   logic       spare_w;
   logic       hi_w;
   logic [2:0] take_byte;
   logic       at_last;
   logic       blk_end;
   logic       adv;
   logic       roll;
   logic       stop_q;
   logic       req_q;

   assign adv  = step && !cmd_vld && !addr_vld && !stop_q;
   assign roll = adv && at_last && !blk_end;

   page_ptr_region u_region (
      .clk, .rst_n, .small_page, .cmd_vld, .cmd_sel, .addr_vld,
      .cmd_take, .spare_q(spare_w), .hi_q(hi_w), .take_byte
   );

   page_ptr_column #(.MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES)) u_col (
      .clk, .rst_n, .small_page, .cmd_take, .cmd_sel,
      .load_first(take_byte[0]), .addr_byte, .spare(spare_w), .hi(hi_w),
      .adv, .blk_end, .at_last, .col_q(col)
   );

   page_ptr_page #(.PG_IN_BLK_W(PG_IN_BLK_W), .BLK_W(BLK_W)) u_page (
      .clk, .rst_n, .load_lo(take_byte[1]), .load_hi(take_byte[2]),
      .addr_byte, .inc(roll), .blk_end, .page_q(page)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stop_q <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         req_q <= take_byte[2] || roll;
         if (take_byte[2])
            stop_q <= 1'b0;
         else if (adv && at_last && blk_end)
            stop_q <= 1'b1;
      end
   end

   assign load_req = req_q;
   assign blk_stop = stop_q;
endmodule

// File: rtl/page_pointer_ctrl_chk.sv
module page_pointer_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        small_page,
   input logic        cmd_vld,
   input logic        addr_vld,
   input logic        step,
   input logic        spare,
   input logic [9:0]  col,
   input logic [14:0] page,
   input logic        load_req,
   input logic        blk_stop
);
   logic [9:0] lim;
   logic       only_step;
   assign lim = small_page ? 10'd511 : 10'd527;
   assign only_step = step && !cmd_vld && !addr_vld && !blk_stop;

   a_r5_col_in_page: assert property (@(posedge clk) disable iff (!rst_n)
      col <= lim);

   a_r4_spare_window: assert property (@(posedge clk) disable iff (!rst_n)
      spare |-> (col >= 10'd512));

   a_r6_step_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (only_step && col != lim) |=> (col == $past(col) + 10'd1));

   a_r7_page_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (only_step && col == lim && page[4:0] != 5'h1f)
      |=> (page == $past(page) + 15'd1 && load_req));

   a_r9_block_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (only_step && col == lim && page[4:0] == 5'h1f)
      |=> (blk_stop && !load_req && $stable(page) && $stable(col)));

   a_r9_stopped_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_stop && step && !cmd_vld && !addr_vld) |=> ($stable(col) && $stable(page)));
endmodule

bind page_pointer_ctrl page_pointer_ctrl_chk u_chk (
   .clk, .rst_n, .small_page, .cmd_vld, .addr_vld, .step,
   .spare(spare_w), .col, .page, .load_req, .blk_stop
);

// File: tb/page_pointer_ctrl_bench.sv
module page_pointer_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        small_page = 1'b0;
   logic        cmd_vld = 1'b0;
   logic [1:0]  cmd_sel = 2'b00;
   logic        addr_vld = 1'b0;
   logic [7:0]  addr_byte = 8'h00;
   logic        step = 1'b0;
   logic [9:0]  col;
   logic [14:0] page;
   logic        load_req;
   logic        blk_stop;
   int          n_chk = 0;
   int          n_bad = 0;

   always #10 clk = ~clk;

   page_pointer_ctrl u_page_pointer_ctrl (
      .clk, .rst_n, .small_page, .cmd_vld, .cmd_sel, .addr_vld, .addr_byte,
      .step, .col, .page, .load_req, .blk_stop
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic sz);
      @(negedge clk);
      rst_n = 1'b0; small_page = sz;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic do_cmd(input logic [1:0] c);
      @(negedge clk);
      cmd_vld = 1'b1; cmd_sel = c;
      @(negedge clk);
      cmd_vld = 1'b0;
   endtask

   task automatic do_addr(input logic [7:0] b);
      @(negedge clk);
      addr_vld = 1'b1; addr_byte = b;
      @(negedge clk);
      addr_vld = 1'b0;
   endtask

   task automatic do_step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         step = 1'b1;
      end
      @(negedge clk);
      step = 1'b0;
   endtask

   task automatic t_reset;
      do_reset(1'b0);
      chk("R1 col", col, 0);
      chk("R1 page", page, 0);
      chk("R1 load_req", load_req, 0);
      chk("R1 blk_stop", blk_stop, 0);
      do_step(3);
      chk("R6 step before address", col, 3);
   endtask

   task automatic t_main;
      do_cmd(2'b00);
      chk("R2 low start", col, 0);
      do_addr(8'h05);
      chk("R3 first byte", col, 5);
      do_addr(8'h23);
      do_addr(8'h81);
      chk("R8 page bit7 ignored", page, 15'h0123);
      chk("R8 load_req on third byte", load_req, 1);
      @(negedge clk);
      chk("R8 load_req one cycle", load_req, 0);
      do_addr(8'h77);
      chk("R8 fourth byte ignored col", col, 5);
      chk("R8 fourth byte ignored page", page, 15'h0123);
      do_step(3);
      chk("R6 three steps", col, 8);
      @(negedge clk);
      cmd_vld = 1'b1; cmd_sel = 2'b01; addr_vld = 1'b1; addr_byte = 8'h09; step = 1'b1;
      @(negedge clk);
      cmd_vld = 1'b0; addr_vld = 1'b0; step = 1'b0;
      chk("R10 command wins", col, 256);
   endtask

   task automatic t_high;
      do_cmd(2'b01);
      chk("R2 high start", col, 256);
      do_addr(8'h10);
      chk("R3 high first byte", col, 272);
      do_addr(8'h40);
      do_addr(8'h00);
      do_step(255);
      chk("R7 at last", col, 527);
      do_step(1);
      chk("R7 wrap col to 0", col, 0);
      chk("R7 page+1", page, 15'h0041);
      chk("R7 load_req", load_req, 1);
   endtask

   task automatic t_spare;
      do_cmd(2'b10);
      chk("R2 spare start", col, 512);
      do_addr(8'hF3);
      chk("R3 spare offset", col, 515);
      do_addr(8'h00);
      do_addr(8'h00);
      do_step(12);
      chk("R5 spare last", col, 527);
      do_step(1);
      chk("R7 spare wrap", col, 512);
      chk("R7 spare page", page, 1);
      chk("R7 spare load_req", load_req, 1);
      do_cmd(2'b11);
      chk("R2 keep cmd col", col, 512);
      do_addr(8'h02);
      chk("R4 spare sticky", col, 514);
      do_addr(8'h05);
      do_addr(8'h00);
      chk("R4 sticky page", page, 5);
      do_cmd(2'b00);
      chk("R4 low cmd leaves spare", col, 0);
      do_addr(8'h02);
      chk("R4 main again", col, 2);
   endtask

   task automatic t_cross;
      do_cmd(2'b00);
      do_addr(8'hFF);
      do_addr(8'h1F);
      do_addr(8'h02);
      chk("R8 page load", page, 15'h021F);
      do_step(272);
      chk("R9 at last", col, 527);
      do_step(1);
      chk("R9 blk_stop", blk_stop, 1);
      chk("R9 no load_req", load_req, 0);
      chk("R9 page held", page, 15'h021F);
      chk("R9 col held", col, 527);
      do_step(4);
      chk("R9 steps ignored", col, 527);
      do_cmd(2'b00);
      chk("R9 stop holds after cmd", blk_stop, 1);
      do_addr(8'h00);
      do_addr(8'h20);
      do_addr(8'h02);
      chk("R8 stop cleared", blk_stop, 0);
      chk("R8 new page", page, 15'h0220);
   endtask

   task automatic t_small;
      do_reset(1'b1);
      do_step(2);
      do_cmd(2'b10);
      chk("R5 spare rejected", col, 2);
      do_cmd(2'b01);
      do_addr(8'hFF);
      chk("R5 small last", col, 511);
      do_addr(8'h00);
      do_addr(8'h00);
      do_step(1);
      chk("R5 small wrap col", col, 0);
      chk("R5 small wrap page", page, 1);
   endtask

   initial begin
      #4000000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_main();
      t_high();
      t_spare();
      t_cross();
      t_small();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end
endmodule